// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and two-digit year. It advances once per pulse on a one-second strobe, `tick_i`, which comes from a prescaler outside the block. Month lengths and leap years are handled in hardware. The hour field runs in 24-hour format or in 12-hour format with a PM flag, and a control bit picks the format.

A rounding command snaps the time to the nearest whole minute. Software loads any field through a simple write port. Every write also raises a one-cycle pulse that tells the external prescaler to restart, so the next tick arrives a full second after the load.

Alarm and interrupt logic next to the block receives one-cycle pulses on each minute rollover and on each day rollover.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the seconds, minutes, hour, day-of-week and year outputs are 00, the day-of-month and month outputs are 01, the format is 24-hour, and all pulse outputs are low.
- R2: Each accepted tick adds one to the seconds. At 59 the seconds return to 00 and the minutes add one. Minutes at 59 return to 00 and carry into the hour.
- R3: When control bit 0 is 0, the hour counts 00 to 23 in BCD. The step from 23 back to 00 advances the date.
- R4: When control bit 0 is 1, hour bits [4:0] hold 01 to 12 in BCD and bit 5 is the PM flag. The sequence is 12, 01, …, 11. The 11→12 step toggles PM. The step from 11 PM to 12 AM advances the date.
- R5: With seconds at 00–29, the round command clears the seconds. With seconds at 30–59, it clears the seconds and adds one minute, with full carry through hour and date.
- R6: The day of month wraps back to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R7: February ends on day 29 when the two-digit year is divisible by 4, including year 00. Otherwise it ends on day 28.
- R8: When the day of month wraps in month 12, the month becomes 01 and the year adds one. The year wraps from 99 to 00.
- R9: The day of week advances with each date step, counting 0 to 6 and wrapping to 0.
- R10: A write loads the field chosen by its address: 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 control (bit 0 selects 12-hour). In a write cycle, a tick or round command is discarded.
- R11: `presc_clr_o` is high for exactly the one cycle after each write, and low at all other times.
- R12: `min_carry_o` and `day_carry_o` are single-cycle pulses. Each appears in the cycle in which the new minute or the new date first shows on the outputs.
- R13: When a round command and a tick arrive in the same cycle, the round command takes effect and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| adj_i | input | 1 | Round-to-nearest-minute command |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field address |
| wr_data_i | input | 8 | Write value (BCD) |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD; bit 5 is PM in 12-hour format |
| wday_o | output | 8 | Day of week 0–6 |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00–99, BCD |
| min_carry_o | output | 1 | Minute rollover pulse |
| day_carry_o | output | 1 | Date rollover pulse |
| presc_clr_o | output | 1 | Prescaler restart pulse |

## Verification
Two kinds of event can land in the same cycle: the round command with a tick, and a write with either of them.

The bench provokes both collisions. It raises tick and round together at seconds 59 and at seconds 10. It also presents a write together with a tick, and a write together with a round command.

A behavioural model applies the fixed priority: a write first, then rounding, then the tick. Every output is compared each cycle. The comparison confirms that the minute advances at most once, and that the discarded event leaves no trace.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef logic [7:0] bcd8_t;

  // add one to a two-digit BCD value, decimal adjusting the low digit
  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [6:0] bcd_to_bin(bcd8_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // two-digit year divisible by four
  function automatic logic is_leap(bcd8_t y);
    return (bcd_to_bin(y) & 7'd3) == 7'd0;
  endfunction

  // last day of month in BCD
  function automatic bcd8_t month_last(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // 12-hour step: bit 5 PM, bits 4:0 BCD 01..12
  function automatic logic [5:0] hour12_inc(logic [5:0] h);
    if (h[4:0] == 5'h12) return {h[5], 5'h01};
    if (h[4:0] == 5'h11) return {~h[5], 5'h12};
    return {h[5], 5'(bcd_inc({3'b000, h[4:0]}))};
  endfunction

endpackage

// File: rtl/rtc_tod.sv
module rtc_tod
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_step,
  input  logic       adj_step,
  input  logic [2:0] wr_sel,
  input  logic [6:0] wr_data,
  input  logic       mode12,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       min_adv,
  output logic       day_adv
);

  logic       sec_wrap;
  logic       adj_up;
  logic       hour_adv;
  logic [6:0] sec_inc;
  logic [6:0] min_inc;
  logic [5:0] hr24_inc;
  logic [5:0] hr12_next;

  assign sec_wrap  = sec_step && (sec_q == 7'h59);
  assign adj_up    = adj_step && (sec_q >= 7'h30);
  assign min_adv   = sec_wrap || adj_up;
  assign hour_adv  = min_adv && (min_q == 7'h59);
  assign day_adv   = hour_adv && (hour_q == (mode12 ? 6'h31 : 6'h23));
  assign sec_inc   = 7'(bcd_inc({1'b0, sec_q}));
  assign min_inc   = 7'(bcd_inc({1'b0, min_q}));
  assign hr24_inc  = 6'(bcd_inc({2'b00, hour_q}));
  assign hr12_next = hour12_inc(hour_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (wr_sel[0])                  sec_q <= wr_data;
      else if (adj_step || sec_wrap)  sec_q <= '0;
      else if (sec_step)              sec_q <= sec_inc;

      if (wr_sel[1])                  min_q <= wr_data;
      else if (hour_adv)              min_q <= '0;
      else if (min_adv)               min_q <= min_inc;

      if (wr_sel[2])                  hour_q <= wr_data[5:0];
      else if (hour_adv)              hour_q <= mode12 ? hr12_next
                                               : (day_adv ? 6'h00 : hr24_inc);
    end
  end

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && sec_q == 7'h59) |=> (sec_q == 7'h00));

  p_adj_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adj_step |=> (sec_q == 7'h00));

  p_hour24_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode12 && hour_adv && hour_q == 6'h23) |=> (hour_q == 6'h00));

  p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode12 && hour_adv && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));

endmodule

// File: rtl/rtc_cal.sv
module rtc_cal
  import rtc_pkg::*;
#(
  parameter int WEEK_DAYS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 day_adv,
  input  logic [3:0]           wr_sel,
  input  logic [7:0]           wr_data,
  output logic [WD_W-1:0]      wday_q,
  output logic [5:0]           mday_q,
  output logic [4:0]           mon_q,
  output logic [7:0]           year_q
);

  localparam int WD_W = $clog2(WEEK_DAYS);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WEEK_DAYS - 1);

  bcd8_t      last_day;
  logic       mday_end;
  logic       mon_end;
  logic [5:0] mday_inc;
  logic [4:0] mon_inc;
  bcd8_t      year_inc;

  assign last_day = month_last({3'b000, mon_q}, year_q);
  assign mday_end = day_adv && ({2'b00, mday_q} == last_day);
  assign mon_end  = mday_end && (mon_q == 5'h12);
  assign mday_inc = 6'(bcd_inc({2'b00, mday_q}));
  assign mon_inc  = 5'(bcd_inc({3'b000, mon_q}));
  assign year_inc = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q <= '0;
      mday_q <= 6'h01;
      mon_q  <= 5'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_sel[0])     wday_q <= wr_data[WD_W-1:0];
      else if (day_adv)  wday_q <= (wday_q == WD_LAST) ? '0 : wday_q + 1'b1;

      if (wr_sel[1])     mday_q <= wr_data[5:0];
      else if (mday_end) mday_q <= 6'h01;
      else if (day_adv)  mday_q <= mday_inc;

      if (wr_sel[2])     mon_q <= wr_data[4:0];
      else if (mon_end)  mon_q <= 5'h01;
      else if (mday_end) mon_q <= mon_inc;

      if (wr_sel[3])     year_q <= wr_data;
      else if (mon_end)  year_q <= year_inc;
    end
  end

  p_mday_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mday_end |=> (mday_q == 6'h01));

  p_feb_leap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && mon_q == 5'h02 && mday_q == 6'h28 && is_leap(year_q)) |=> (mday_q == 6'h29));

  p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_end && year_q == 8'h99) |=> (year_q == 8'h00 && mon_q == 5'h01));

  p_wday_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (day_adv && wday_q == WD_LAST) |=> (wday_q == '0));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int WEEK_DAYS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              adj_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] hour_o,
  output logic [DATA_W-1:0] wday_o,
  output logic [DATA_W-1:0] mday_o,
  output logic [DATA_W-1:0] mon_o,
  output logic [DATA_W-1:0] year_o,
  output logic              min_carry_o,
  output logic              day_carry_o,
  output logic              presc_clr_o
);

  localparam int FIELDS  = 1 << ADDR_W;
  localparam int WD_W    = $clog2(WEEK_DAYS);
  localparam int A_SEC   = 0;
  localparam int A_WDAY  = 3;
  localparam int A_CTRL  = 7;

  logic [FIELDS-1:0] wr_sel;
  logic              sec_step;
  logic              adj_step;
  logic              mode12_q;
  logic              min_adv;
  logic              day_adv;
  logic [6:0]        sec_q;
  logic [6:0]        min_q;
  logic [5:0]        hour_q;
  logic [WD_W-1:0]   wday_q;
  logic [5:0]        mday_q;
  logic [4:0]        mon_q;
  logic [7:0]        year_q;

  for (genvar i = 0; i < FIELDS; i++) begin : g_wsel
    assign wr_sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  // priority: write, then rounding, then tick
  assign adj_step = adj_i && !wr_en_i;
  assign sec_step = tick_i && !adj_i && !wr_en_i;

  rtc_tod u_tod (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_step (sec_step),
    .adj_step (adj_step),
    .wr_sel   (wr_sel[A_SEC +: 3]),
    .wr_data  (wr_data_i[6:0]),
    .mode12   (mode12_q),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hour_q   (hour_q),
    .min_adv  (min_adv),
    .day_adv  (day_adv)
  );

  rtc_cal #(.WEEK_DAYS(WEEK_DAYS)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .day_adv (day_adv),
    .wr_sel  (wr_sel[A_WDAY +: 4]),
    .wr_data (wr_data_i[7:0]),
    .wday_q  (wday_q),
    .mday_q  (mday_q),
    .mon_q   (mon_q),
    .year_q  (year_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode12_q    <= 1'b0;
      min_carry_o <= 1'b0;
      day_carry_o <= 1'b0;
      presc_clr_o <= 1'b0;
    end else begin
      if (wr_sel[A_CTRL]) mode12_q <= wr_data_i[0];
      min_carry_o <= min_adv;
      day_carry_o <= day_adv;
      presc_clr_o <= wr_en_i;
    end
  end

  assign sec_o  = DATA_W'(sec_q);
  assign min_o  = DATA_W'(min_q);
  assign hour_o = DATA_W'(hour_q);
  assign wday_o = DATA_W'(wday_q);
  assign mday_o = DATA_W'(mday_q);
  assign mon_o  = DATA_W'(mon_q);
  assign year_o = DATA_W'(year_q);

  p_presc_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> presc_clr_o);

  p_min_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry_o |-> (sec_o == '0));

  p_day_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry_o |-> (hour_o == DATA_W'(8'h00) || hour_o == DATA_W'(8'h12)));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == ADDR_W'(A_SEC)) |=> (sec_o == DATA_W'($past(wr_data_i[6:0]))));

  p_round_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && adj_i && !wr_en_i) |=> (sec_o == '0));

endmodule

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, adj = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic       min_carry_o, day_carry_o, presc_clr_o;

  always #2.5 clk = ~clk;

  bcd_rtc_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .adj_i(adj),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .min_carry_o(min_carry_o), .day_carry_o(day_carry_o), .presc_clr_o(presc_clr_o)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit armed = 0, done = 0;

  // reference state, plain integers
  int m_sec, m_min, m_hraw, m_wday, m_mday, m_mon, m_year;
  bit m_m12, e_mc, e_dc, e_pc;
  bit mc, dc;
  int h, pm;

  function automatic int tobcd(int n); return (n / 10) * 16 + (n % 10); endfunction
  function automatic int frombcd(int b); return (b / 16) * 10 + (b % 16); endfunction
  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hraw = 0; m_wday = 0; m_mday = 1; m_mon = 1; m_year = 0;
      m_m12 = 0; e_mc = 0; e_dc = 0; e_pc = 0;
    end else begin
      mc = 0; dc = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sec  = frombcd(wr_data & 8'h7f);
          3'd1: m_min  = frombcd(wr_data & 8'h7f);
          3'd2: m_hraw = wr_data & 8'h3f;
          3'd3: m_wday = wr_data & 8'h07;
          3'd4: m_mday = frombcd(wr_data & 8'h3f);
          3'd5: m_mon  = frombcd(wr_data & 8'h1f);
          3'd6: m_year = frombcd(wr_data);
          default: m_m12 = wr_data[0];
        endcase
      end else if (adj) begin
        if (m_sec >= 30) mc = 1;
        m_sec = 0;
      end else if (tick) begin
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; mc = 1; end
      end
      if (mc) begin
        m_min++;
        if (m_min == 60) begin
          m_min = 0;
          if (!m_m12) begin
            h = frombcd(m_hraw) + 1;
            if (h == 24) begin h = 0; dc = 1; end
            m_hraw = tobcd(h);
          end else begin
            h = frombcd(m_hraw & 8'h1f);
            pm = (m_hraw >> 5) & 1;
            if (h == 12) h = 1;
            else if (h == 11) begin h = 12; if (pm == 1) dc = 1; pm = 1 - pm; end
            else h++;
            m_hraw = tobcd(h) + pm * 32;
          end
        end
      end
      if (dc) begin
        m_wday = (m_wday + 1) % 7;
        if (m_mday >= mlen(m_mon, m_year)) begin
          m_mday = 1;
          if (m_mon == 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          else m_mon++;
        end else m_mday++;
      end
      e_mc = mc; e_dc = dc; e_pc = wr_en;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(cur_req, "sec",  sec_o,  tobcd(m_sec));
      chk(cur_req, "min",  min_o,  tobcd(m_min));
      chk(cur_req, "hour", hour_o, m_hraw);
      chk(cur_req, "wday", wday_o, m_wday);
      chk(cur_req, "mday", mday_o, tobcd(m_mday));
      chk(cur_req, "mon",  mon_o,  tobcd(m_mon));
      chk(cur_req, "year", year_o, tobcd(m_year));
      chk("R12", "min_carry", min_carry_o, e_mc);
      chk("R12", "day_carry", day_carry_o, e_dc);
      chk("R11", "presc_clr", presc_clr_o, e_pc);
    end
  end

  task automatic drive(bit t, bit a, bit w, int ad, int d);
    @(negedge clk);
    tick = t; adj = a; wr_en = w; wr_addr = 3'(ad); wr_data = 8'(d);
  endtask
  task automatic wr(int ad, int d); drive(0, 0, 1, ad, d); endtask
  task automatic tk(); drive(1, 0, 0, 0, 0); endtask
  task automatic rnd(); drive(0, 1, 0, 0, 0); endtask
  task automatic idle(); drive(0, 0, 0, 0, 0); endtask
  task automatic set_time(int hh, int mm, int ss); wr(2, hh); wr(1, mm); wr(0, ss); endtask
  task automatic set_date(int wd, int dd, int mo, int yy); wr(3, wd); wr(4, dd); wr(5, mo); wr(6, yy); endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "sec",  sec_o, 0);     chk("R1", "min", min_o, 0);
    chk("R1", "hour", hour_o, 0);    chk("R1", "wday", wday_o, 0);
    chk("R1", "mday", mday_o, 1);    chk("R1", "mon", mon_o, 1);
    chk("R1", "year", year_o, 0);    chk("R1", "carries", {min_carry_o, day_carry_o, presc_clr_o}, 0);
    rst_n = 1'b1;
    armed = 1;
    cur_req = "R2";
    repeat (125) tk();
    idle();
    set_time(8'h05, 8'h59, 8'h58);
    repeat (3) tk();
    idle();
    cur_req = "R9";
    set_date(6, 8'h15, 8'h03, 8'h21);
    cur_req = "R3";
    set_time(8'h23, 8'h59, 8'h59);
    tk(); idle(); tk(); idle();
    cur_req = "R4";
    wr(7, 1);
    set_time(8'h11, 8'h59, 8'h59); tk(); idle();
    set_time(8'h31, 8'h59, 8'h59); tk(); idle();
    set_time(8'h12, 8'h59, 8'h59); tk(); idle();
    set_time(8'h32, 8'h59, 8'h59); tk(); idle();
    wr(7, 0);
    cur_req = "R5";
    set_time(8'h10, 8'h20, 8'h29); rnd(); idle();
    wr(0, 8'h30); rnd(); idle();
    wr(0, 8'h00); rnd(); idle();
    set_time(8'h23, 8'h59, 8'h45); rnd(); idle();
    for (int y = 0; y < 3; y++) begin
      int yr;
      yr = (y == 0) ? 23 : ((y == 1) ? 24 : 0);
      for (int mo = 1; mo <= 12; mo++) begin
        cur_req = (mo == 2) ? "R7" : "R6";
        set_date(2, tobcd(mlen(mo, yr)), tobcd(mo), tobcd(yr));
        set_time(8'h23, 8'h59, 8'h59);
        tk(); idle();
      end
    end
    cur_req = "R7";
    set_date(1, 8'h28, 8'h02, 8'h24); set_time(8'h23, 8'h59, 8'h59); tk(); idle();
    set_date(1, 8'h28, 8'h02, 8'h25); set_time(8'h23, 8'h59, 8'h59); tk(); idle();
    cur_req = "R8";
    set_date(2, 8'h31, 8'h12, 8'h99); set_time(8'h23, 8'h59, 8'h59); tk(); idle();
    set_date(2, 8'h31, 8'h12, 8'h42); set_time(8'h23, 8'h59, 8'h59); tk(); idle();
    cur_req = "R10";
    set_time(8'h01, 8'h10, 8'h10);
    drive(1, 0, 1, 0, 8'h40); idle();
    drive(0, 1, 1, 1, 8'h22); idle();
    wr(0, 8'h45); drive(0, 1, 1, 3, 5); idle();
    cur_req = "R13";
    set_time(8'h01, 8'h10, 8'h59); drive(1, 1, 0, 0, 0); idle();
    wr(0, 8'h10); drive(1, 1, 0, 0, 0); idle();
    repeat (3) idle();
    done = 1;
    summary();
  end

endmodule